// File: doc/BRIEF.md
# Host-DSP Command Status Mailbox

This block is the register set a bus host uses to talk to an on-card DSP. The host writes a command word and a parameter word. The DSP answers through a query response word. A 16-bit status word reports how the exchange stands. The DSP raises two handshake flags with one-cycle set pulses. "Command slot free" means the host may write a new command and parameter. "Query answer present" means the response word holds a result. Any host write to the command register clears both flags in hardware. That write also sends a one-cycle strobe to the DSP.

The status word also shows several DSP-driven bits: a completion bit, an active-low error bit, self-test done, model code loaded, and hardware configured. It shows a data-available bit, derived from a word-count input. It also shows two lifecycle bits, Passed and Ready. These come from a registered lifecycle state code. Ready means different things depending on Passed. Before the device has passed, Ready marks the configuration-init state. After it has passed, Ready follows the DSP's initialization-finished input.

Top module: `dsp_mailbox`

## Requirements
- R1: When `host_wr_en` is 1, `host_wr_sel`=0 loads the command register and `host_wr_sel`=1 loads the parameter register at the clock edge. The read select codes are 1 for command, 2 for parameter and 3 for query response. `cmd_word`/`param_word` show the stored values from the next cycle on.
- R2: The command-free flag (status bit 0) becomes 1 in the cycle after `dsp_cmd_free_set` is pulsed. It stays 1 until a host command write, after which it reads 0 in the next cycle.
- R3: The answer-present flag (status bit 1) becomes 1 in the cycle after `dsp_ans_set` is pulsed. It is cleared the same way by a host command write.
- R4: When a set pulse and a host command write fall in the same cycle, the flag reads 0 afterwards.
- R5: A host write to the parameter register leaves both flags unchanged.
- R6: Passed (status bit 5) is 1 exactly when the lifecycle code registered at the previous edge is 6 (passed). The codes are 0 hard reset, 1 soft reset, 2 configuration init, 3 self test, 4 failed and 5 init failed. Code 7 counts as hard reset.
- R7: Ready (status bit 4) has two cases. While Passed is 0, it is 1 only for registered code 2. While Passed is 1, it equals `dsp_init_done`.
- R8: Data-available (status bit 9) is 1 when `send_words` is nonzero and 0 when it is zero.
- R9: These DSP inputs appear directly in the status word: done (bit 2), err_n (bit 3), hw_ok (bit 6), self-test done (bit 7) and loaded (bit 8). Bits 15..10 read 0.
- R10: After a synchronous reset, both flags are 0, all three data registers are 0, Passed and Ready are 0, and the lifecycle is treated as hard reset.
- R11: `dsp_ans_we` loads `dsp_ans_data` into the query response register, which reads back under select 3. Reads through `host_rd_sel` change no state.
- R12: `cmd_strobe` is 1 for exactly the one cycle after each host command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write enable |
| host_wr_sel | input | 1 | Host write target: 0 command, 1 parameter |
| host_wr_data | input | 16 | Host write data |
| host_rd_sel | input | 2 | Read select: 0 status, 1 command, 2 parameter, 3 response |
| host_rd_data | output | 16 | Selected read data |
| dsp_cmd_free_set | input | 1 | DSP pulse: command slot is free |
| dsp_ans_set | input | 1 | DSP pulse: query answer present |
| dsp_ans_we | input | 1 | DSP loads the query response register |
| dsp_ans_data | input | 16 | Query response data |
| dsp_done | input | 1 | DSP finished last command |
| dsp_err_n | input | 1 | Active-low DSP error |
| dsp_selftest_ok | input | 1 | DSP self test completed and passed |
| dsp_loaded | input | 1 | DSP booted with valid model code |
| dsp_init_done | input | 1 | DSP initialization finished |
| hw_ok | input | 1 | All on-card FPGAs configured |
| life_state | input | 3 | Device lifecycle code |
| send_words | input | 8 | Words waiting in the send-data store |
| cmd_word | output | 16 | Stored command word |
| param_word | output | 16 | Stored parameter word |
| cmd_strobe | output | 1 | One-cycle pulse after a host command write |
| status_word | output | 16 | Packed status word |

## Verification
Some behaviour is checked by assertions on every cycle. For each flag, they check that a command write clears it and wins over a simultaneous set, that a lone set raises it, and that it holds otherwise. They also check that Passed and Ready follow the previously registered lifecycle code, and that the strobe follows every command write. The bench sweeps every lifecycle code against both initialization inputs, every pass-through bit pattern, and a range of word counts. Two things show up only in its scenarios: the register contents on read-back, and the fact that parameter writes and reads leave the flags alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int STW = 16;

  typedef enum logic [2:0] {
    LC_HARD   = 3'd0,
    LC_SOFT   = 3'd1,
    LC_CFG    = 3'd2,
    LC_SELF   = 3'd3,
    LC_FAIL   = 3'd4,
    LC_IFAIL  = 3'd5,
    LC_PASSED = 3'd6,
    LC_RSVD   = 3'd7
  } life_e;

  // status bit positions
  localparam int B_CMDFREE = 0;
  localparam int B_ANS     = 1;
  localparam int B_DONE    = 2;
  localparam int B_ERRN    = 3;
  localparam int B_READY   = 4;
  localparam int B_PASSED  = 5;
  localparam int B_HWOK    = 6;
  localparam int B_STOK    = 7;
  localparam int B_LOADED  = 8;
  localparam int B_DATA    = 9;

  typedef struct packed {
    logic cmd_free;
    logic ans;
    logic done;
    logic err_n;
    logic ready;
    logic passed;
    logic hw_ok;
    logic st_ok;
    logic loaded;
    logic data;
  } stat_t;

  function automatic life_e life_sanitize(input logic [2:0] code);
    return (code == 3'd7) ? LC_HARD : life_e'(code);
  endfunction

  function automatic logic life_passed(input life_e s);
    return s == LC_PASSED;
  endfunction

  function automatic logic life_ready(input life_e s, input logic init_done);
    return life_passed(s) ? init_done : (s == LC_CFG);
  endfunction

  function automatic logic [STW-1:0] pack_status(input stat_t s);
    logic [STW-1:0] w;
    w = '0;
    w[B_CMDFREE] = s.cmd_free;
    w[B_ANS]     = s.ans;
    w[B_DONE]    = s.done;
    w[B_ERRN]    = s.err_n;
    w[B_READY]   = s.ready;
    w[B_PASSED]  = s.passed;
    w[B_HWOK]    = s.hw_ok;
    w[B_STOK]    = s.st_ok;
    w[B_LOADED]  = s.loaded;
    w[B_DATA]    = s.data;
    return w;
  endfunction
endpackage

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !flag_o);
  p_set_raises_r2: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> flag_o);
  p_flag_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/mbx_life.sv
module mbx_life
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] life_i,
  input  logic       init_done_i,
  output logic       passed_o,
  output logic       ready_o
);
  life_e life_q;
  logic  run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      life_q <= LC_HARD;
      run_q  <= 1'b0;
    end else begin
      life_q <= life_sanitize(life_i);
      run_q  <= 1'b1;
    end
  end

  assign passed_o = life_passed(life_q);
  assign ready_o  = life_ready(life_q, init_done_i);

  p_passed_code_r6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (passed_o == ($past(life_i) == 3'd6)));
  p_ready_cfg_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q && !passed_o) |-> (ready_o == ($past(life_i) == 3'd2)));
  p_ready_init_r7: assert property (@(posedge clk) disable iff (rst)
    passed_o |-> (ready_o == init_done_i));
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we_i,
  input  logic          par_we_i,
  input  logic [DW-1:0] host_d_i,
  input  logic          ans_we_i,
  input  logic [DW-1:0] ans_d_i,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] par_o,
  output logic [DW-1:0] ans_o,
  output logic          strobe_o
);
  logic [DW-1:0] cmd_q, par_q, ans_q;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      par_q <= '0;
      ans_q <= '0;
      stb_q <= 1'b0;
    end else begin
      if (cmd_we_i) cmd_q <= host_d_i;
      if (par_we_i) par_q <= host_d_i;
      if (ans_we_i) ans_q <= ans_d_i;
      stb_q <= cmd_we_i;
    end
  end

  assign cmd_o    = cmd_q;
  assign par_o    = par_q;
  assign ans_o    = ans_q;
  assign strobe_o = stb_q;

  p_strobe_follows_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_we_i |=> strobe_o);
  p_strobe_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !cmd_we_i |=> !strobe_o);
  p_cmd_loaded_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_we_i |=> (cmd_o == $past(host_d_i)));
  p_param_loaded_r1: assert property (@(posedge clk) disable iff (rst)
    par_we_i |=> (par_o == $past(host_d_i)));
endmodule

// File: rtl/dsp_mailbox.sv
module dsp_mailbox
  import mbx_pkg::*;
#(
  parameter int DW   = 16,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr_en,
  input  logic            host_wr_sel,
  input  logic [DW-1:0]   host_wr_data,
  input  logic [1:0]      host_rd_sel,
  output logic [DW-1:0]   host_rd_data,
  input  logic            dsp_cmd_free_set,
  input  logic            dsp_ans_set,
  input  logic            dsp_ans_we,
  input  logic [DW-1:0]   dsp_ans_data,
  input  logic            dsp_done,
  input  logic            dsp_err_n,
  input  logic            dsp_selftest_ok,
  input  logic            dsp_loaded,
  input  logic            dsp_init_done,
  input  logic            hw_ok,
  input  logic [2:0]      life_state,
  input  logic [CNTW-1:0] send_words,
  output logic [DW-1:0]   cmd_word,
  output logic [DW-1:0]   param_word,
  output logic            cmd_strobe,
  output logic [STW-1:0]  status_word
);
  localparam int NFLAG = 2;

  // named internal events
  logic cmd_write_ev, par_write_ev;
  assign cmd_write_ev = host_wr_en && !host_wr_sel;
  assign par_write_ev = host_wr_en &&  host_wr_sel;

  logic [NFLAG-1:0] flag_set, flag_val;
  assign flag_set = {dsp_ans_set, dsp_cmd_free_set};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    mbx_flag u_flag (
      .clk   (clk),
      .rst   (rst),
      .set_i (flag_set[g]),
      .clr_i (cmd_write_ev),
      .flag_o(flag_val[g])
    );
  end

  logic passed_w, ready_w;
  mbx_life u_life (
    .clk        (clk),
    .rst        (rst),
    .life_i     (life_state),
    .init_done_i(dsp_init_done),
    .passed_o   (passed_w),
    .ready_o    (ready_w)
  );

  logic [DW-1:0] ans_w;
  mbx_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .cmd_we_i(cmd_write_ev),
    .par_we_i(par_write_ev),
    .host_d_i(host_wr_data),
    .ans_we_i(dsp_ans_we),
    .ans_d_i (dsp_ans_data),
    .cmd_o   (cmd_word),
    .par_o   (param_word),
    .ans_o   (ans_w),
    .strobe_o(cmd_strobe)
  );

  stat_t st;
  always_comb begin
    st.cmd_free = flag_val[0];
    st.ans      = flag_val[1];
    st.done     = dsp_done;
    st.err_n    = dsp_err_n;
    st.ready    = ready_w;
    st.passed   = passed_w;
    st.hw_ok    = hw_ok;
    st.st_ok    = dsp_selftest_ok;
    st.loaded   = dsp_loaded;
    st.data     = |send_words;
  end
  assign status_word = pack_status(st);

  logic [DW-1:0] stat_ext;
  always_comb begin
    stat_ext = '0;
    stat_ext[STW-1:0] = status_word;
  end

  always_comb begin
    unique case (host_rd_sel)
      2'd0:    host_rd_data = stat_ext;
      2'd1:    host_rd_data = cmd_word;
      2'd2:    host_rd_data = param_word;
      default: host_rd_data = ans_w;
    endcase
  end

  p_flags_clear_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_write_ev |=> (status_word[1:0] == 2'b00));
  p_answer_loaded_r11: assert property (@(posedge clk) disable iff (rst)
    dsp_ans_we |=> (ans_w == $past(dsp_ans_data)));
endmodule

// File: tb/test_dsp_mailbox.sv
module test_dsp_mailbox;
  logic clk = 0, rst = 1;
  logic host_wr_en = 0, host_wr_sel = 0;
  logic [15:0] host_wr_data = 0;
  logic [1:0] host_rd_sel = 0;
  logic [15:0] host_rd_data;
  logic dsp_cmd_free_set = 0, dsp_ans_set = 0, dsp_ans_we = 0;
  logic [15:0] dsp_ans_data = 0;
  logic dsp_done = 0, dsp_err_n = 0, dsp_selftest_ok = 0, dsp_loaded = 0;
  logic dsp_init_done = 0, hw_ok = 0;
  logic [2:0] life_state = 0;
  logic [7:0] send_words = 0;
  logic [15:0] cmd_word, param_word, status_word;
  logic cmd_strobe;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dsp_mailbox i_dsp_mailbox (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic host_write(input logic sel, input logic [15:0] d);
    host_wr_en = 1; host_wr_sel = sel; host_wr_data = d;
    tick();
    host_wr_en = 0;
  endtask

  function automatic logic exp_ready(input int code, input logic init);
    if (code == 6) return init;
    return code == 2;
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst = 0;
    // R10 reset state
    chk("R10 status", status_word, 16'h0000);
    chk("R10 cmd", cmd_word, 0);
    chk("R10 param", param_word, 0);
    host_rd_sel = 3; #1 chk("R10 ans", host_rd_data, 0);
    host_rd_sel = 0;

    // R1 / R12 writes and strobe
    host_write(0, 16'hA5C3);
    chk("R12 strobe", {15'd0, cmd_strobe}, 1);
    chk("R1 cmd", cmd_word, 16'hA5C3);
    host_rd_sel = 1; #1 chk("R1 rd cmd", host_rd_data, 16'hA5C3);
    tick();
    chk("R12 strobe off", {15'd0, cmd_strobe}, 0);
    host_write(1, 16'h1234);
    chk("R12 no strobe param", {15'd0, cmd_strobe}, 0);
    host_rd_sel = 2; #1 chk("R1 rd param", host_rd_data, 16'h1234);
    chk("R1 cmd kept", cmd_word, 16'hA5C3);

    // R11 response register
    dsp_ans_we = 1; dsp_ans_data = 16'hBEEF; tick(); dsp_ans_we = 0;
    host_rd_sel = 3; #1 chk("R11 ans", host_rd_data, 16'hBEEF);
    host_rd_sel = 0;

    // R2 / R3 set and hold
    dsp_cmd_free_set = 1; tick(); dsp_cmd_free_set = 0;
    chk("R2 set", {14'd0, status_word[1:0]}, 16'd1);
    dsp_ans_set = 1; tick(); dsp_ans_set = 0;
    chk("R3 set", {14'd0, status_word[1:0]}, 16'd3);
    for (int k = 0; k < 4; k++) begin
      host_rd_sel = 2'(k); tick();
    end
    host_rd_sel = 0;
    chk("R11 reads no effect", {14'd0, status_word[1:0]}, 16'd3);
    // R5 param write keeps flags
    host_write(1, 16'h0F0F);
    chk("R5 flags kept", {14'd0, status_word[1:0]}, 16'd3);
    // R2/R3 clear by command write
    host_write(0, 16'h0001);
    chk("R2 R3 clear", {14'd0, status_word[1:0]}, 16'd0);
    // R4 collisions
    dsp_cmd_free_set = 1; dsp_ans_set = 1;
    host_write(0, 16'h0002);
    dsp_cmd_free_set = 0; dsp_ans_set = 0;
    chk("R4 clear wins", {14'd0, status_word[1:0]}, 16'd0);
    dsp_ans_set = 1; tick(); dsp_ans_set = 0;
    chk("R3 only ans", {14'd0, status_word[1:0]}, 16'd2);
    dsp_cmd_free_set = 1; host_write(0, 16'h0003); dsp_cmd_free_set = 0;
    chk("R4 cmd collide", {14'd0, status_word[1:0]}, 16'd0);

    // R6 / R7 lifecycle sweep
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 2; i++) begin
        life_state = 3'(c); dsp_init_done = 1'(i);
        tick();
        chk("R6 passed", {15'd0, status_word[5]}, {15'd0, c == 6});
        chk("R7 ready", {15'd0, status_word[4]}, {15'd0, exp_ready(c, 1'(i))});
      end
    end
    // R6 registered: change code, check before edge
    life_state = 6; tick();
    life_state = 0; #1;
    chk("R6 registered", {15'd0, status_word[5]}, 1);
    tick();
    chk("R6 after edge", {15'd0, status_word[5]}, 0);

    // R9 pass-through sweep
    for (int p = 0; p < 32; p++) begin
      logic [4:0] v;
      logic [15:0] e;
      v = 5'(p);
      dsp_done = v[0]; dsp_err_n = v[1]; hw_ok = v[2];
      dsp_selftest_ok = v[3]; dsp_loaded = v[4];
      #1;
      e = (16'(v[0]) << 2) + (16'(v[1]) << 3) + (16'(v[2]) << 6)
        + (16'(v[3]) << 7) + (16'(v[4]) << 8);
      chk("R9 bits", status_word & 16'hFDCC, e);
      chk("R9 upper zero", status_word & 16'hFC00, 0);
    end

    // R8 data available
    for (int w = 0; w < 256; w += 17) begin
      send_words = 8'(w); #1;
      chk("R8 data", {15'd0, status_word[9]}, {15'd0, w != 0});
    end
    send_words = 8'd1; #1 chk("R8 one", {15'd0, status_word[9]}, 1);

    // R10 reset again
    dsp_cmd_free_set = 1; tick(); dsp_cmd_free_set = 0;
    life_state = 6; tick();
    rst = 1; tick(); rst = 0;
    chk("R10 flags", {14'd0, status_word[1:0]}, 0);
    chk("R10 passed", {15'd0, status_word[5]}, 0);
    chk("R10 cmd", cmd_word, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule